// File: doc/BRIEF.md
# Vectored-by-Message Interrupt Arbiter

This block gathers interrupt requests from a set of I/O units and drives one shared interrupt line toward the processor. The line only says that some unit wants service; it carries nothing about which one. The processor looks at the line once per instruction. When it answers with an acknowledge, the arbiter picks one requesting unit by fixed priority, with the lowest index winning. It then sends a one-cycle acknowledge to that unit alone.

The acknowledged unit owns the I/O bus until it has delivered a two-word message. The first word is an event identifier and the second is a parameter for the service routine. The arbiter passes each word through a registered output stage to the processor with a valid/ready handshake and marks the second word as the last. While a message is in flight the interrupt line is held low, and requests that arrive meanwhile stay pending. Once the processor takes the second word, the line is recomputed from the requests that remain.

Top module: `irq_msg_arbiter`

## Requirements
- R1: While no message is in flight, `cpu_irq` equals the OR of `unit_req` as sampled on the previous clock edge; it is a single bit with no unit identity.
- R2: A `cpu_ack` sampled high while `cpu_irq` is high makes, one cycle later, exactly one bit of `unit_ack` high for one cycle: the lowest-index bit of `unit_req` sampled together with that `cpu_ack`.
- R3: A `cpu_ack` sampled while `cpu_irq` is low, whether idle or during a message, produces no `unit_ack` bit.
- R4: During a message only the acknowledged unit sees `unit_ready` high; `unit_valid` and `unit_data` of any other unit have no effect on the forwarded words.
- R5: The acknowledged unit's words are forwarded in order with unchanged data: the first (event identifier) with `msg_last`=0, the second (parameter) with `msg_last`=1, and no further word from that message.
- R6: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_data` and `msg_last` hold their values on the next cycle.
- R7: `cpu_irq` stays low from the acknowledge until the processor accepts the second word, even if other units raise requests in that time.
- R8: In the cycle after the processor accepts the second word, `cpu_irq` equals the OR of `unit_req` as sampled with that acceptance, so held requests are served next.
- R9: After the synchronous active-high reset, `cpu_irq`, `unit_ack`, `unit_ready` and `msg_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_req | input | N_UNITS | Interrupt request, one bit per unit |
| unit_ack | output | N_UNITS | One-cycle acknowledge to the selected unit |
| unit_valid | input | N_UNITS | Word valid from each unit on the I/O bus |
| unit_data | input | N_UNITS*WORD_W | Word data from each unit, unit i in bits [i*WORD_W +: WORD_W] |
| unit_ready | output | N_UNITS | Word ready to each unit, high only for the bus owner |
| cpu_irq | output | 1 | Combined interrupt line to the processor |
| cpu_ack | input | 1 | Interrupt acknowledge from the processor |
| msg_valid | output | 1 | Forwarded word valid |
| msg_data | output | WORD_W | Forwarded word |
| msg_last | output | 1 | 0 on the event identifier, 1 on the parameter |
| msg_ready | input | 1 | Processor accepts the forwarded word |

## Verification
Requests are raised all at once and served one by one, so the grant order can be told apart from arrival order and the line re-raising after each message is exercised. Random request masks with a processor that stalls at random separate correct selection and word order from mere data passing, because the forwarded payload must match the identity of the expected winner. Stray acknowledges, late requests and garbage valid/data from units that do not own the bus are injected during messages. These show that the line stays low, that no second acknowledge leaks out, and that only the owner's words pass through.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_XFER = 1'b1
  } arb_state_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_UNITS = 4
) (
  input  logic [N_UNITS-1:0] req,
  output logic [N_UNITS-1:0] grant,
  output logic               any
);
  logic [N_UNITS:0] lower_seen;

  assign lower_seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < N_UNITS; i++) begin : g_pick
      assign grant[i]        = req[i] & ~lower_seen[i];
      assign lower_seen[i+1] = lower_seen[i] | req[i];
    end
  endgenerate

  assign any = lower_seen[N_UNITS];
endmodule

// File: rtl/irq_bus_mux.sv
module irq_bus_mux #(
  parameter int N_UNITS = 4,
  parameter int WORD_W  = 32
) (
  input  logic [N_UNITS-1:0]        owner,
  input  logic                      allow,
  input  logic [N_UNITS-1:0]        src_valid,
  input  logic [N_UNITS*WORD_W-1:0] src_data,
  output logic [N_UNITS-1:0]        src_ready,
  output logic                      sel_valid,
  output logic [WORD_W-1:0]         sel_data
);
  logic [WORD_W-1:0] masked [N_UNITS];
  logic [WORD_W-1:0] acc    [N_UNITS+1];

  assign acc[0] = '0;

  generate
    for (genvar i = 0; i < N_UNITS; i++) begin : g_lane
      assign masked[i]    = src_data[i*WORD_W +: WORD_W] & {WORD_W{owner[i]}};
      assign acc[i+1]     = acc[i] | masked[i];
      assign src_ready[i] = owner[i] & allow;
    end
  endgenerate

  assign sel_valid = |(src_valid & owner);
  assign sel_data  = acc[N_UNITS];
endmodule

// File: rtl/irq_msg_reg.sv
module irq_msg_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic              out_ready,
  output logic              space,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  assign space = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_last  <= in_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_msg_arbiter.sv
module irq_msg_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int WORD_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_UNITS-1:0]        unit_req,
  output logic [N_UNITS-1:0]        unit_ack,
  input  logic [N_UNITS-1:0]        unit_valid,
  input  logic [N_UNITS*WORD_W-1:0] unit_data,
  output logic [N_UNITS-1:0]        unit_ready,
  output logic                      cpu_irq,
  input  logic                      cpu_ack,
  output logic                      msg_valid,
  output logic [WORD_W-1:0]         msg_data,
  output logic                      msg_last,
  input  logic                      msg_ready
);
  arb_state_t          state_q, state_d;
  logic [N_UNITS-1:0]  owner_q;
  logic [N_UNITS-1:0]  ack_q;
  logic                irq_q;
  logic                second_q;
  logic                src_done_q;

  logic [N_UNITS-1:0]  grant;
  logic                any_req;
  logic                take;
  logic                allow;
  logic                space;
  logic                sel_valid;
  logic [WORD_W-1:0]   sel_data;
  logic                src_fire;
  logic                consume;

  irq_prio_pick #(.N_UNITS(N_UNITS)) u_pick (
    .req   (unit_req),
    .grant (grant),
    .any   (any_req)
  );

  irq_bus_mux #(.N_UNITS(N_UNITS), .WORD_W(WORD_W)) u_mux (
    .owner     (owner_q),
    .allow     (allow),
    .src_valid (unit_valid),
    .src_data  (unit_data),
    .src_ready (unit_ready),
    .sel_valid (sel_valid),
    .sel_data  (sel_data)
  );

  irq_msg_reg #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (src_fire),
    .in_data   (sel_data),
    .in_last   (second_q),
    .out_ready (msg_ready),
    .space     (space),
    .out_valid (msg_valid),
    .out_data  (msg_data),
    .out_last  (msg_last)
  );

  // acknowledge is honoured only while the line is up and idle
  assign take     = (state_q == ARB_IDLE) & cpu_ack & irq_q & any_req;
  assign allow    = (state_q == ARB_XFER) & ~src_done_q & space;
  assign src_fire = sel_valid & allow;
  assign consume  = msg_valid & msg_ready & msg_last;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ARB_IDLE: if (take)    state_d = ARB_XFER;
      ARB_XFER: if (consume) state_d = ARB_IDLE;
      default:               state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ARB_IDLE;
      owner_q    <= '0;
      ack_q      <= '0;
      irq_q      <= 1'b0;
      second_q   <= 1'b0;
      src_done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_d == ARB_IDLE) & (|unit_req);
      ack_q   <= take ? grant : '0;
      if (take)         owner_q <= grant;
      else if (consume) owner_q <= '0;
      if (take) begin
        second_q   <= 1'b0;
        src_done_q <= 1'b0;
      end else if (src_fire) begin
        second_q   <= 1'b1;
        src_done_q <= second_q;
      end
    end
  end

  assign unit_ack = ack_q;
  assign cpu_irq  = irq_q;
endmodule

// File: rtl/irq_msg_arbiter_chk.sv
module irq_msg_arbiter_chk #(
  parameter int N_UNITS = 4,
  parameter int WORD_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [N_UNITS-1:0] unit_ack,
  input logic [N_UNITS-1:0] unit_ready,
  input logic               cpu_irq,
  input logic               cpu_ack,
  input logic               msg_valid,
  input logic [WORD_W-1:0]  msg_data,
  input logic               msg_last,
  input logic               msg_ready
);
  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_ack));

  // R3
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|unit_ack) |-> ($past(cpu_ack) && $past(cpu_irq)));

  // R4
  ready_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_ready));

  // R6
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_last)));

  // R7
  irq_low_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (|unit_ack) |-> !cpu_irq);

  // R7
  irq_low_in_msg_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !cpu_irq);
endmodule

bind irq_msg_arbiter irq_msg_arbiter_chk #(.N_UNITS(N_UNITS), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .unit_ack   (unit_ack),
  .unit_ready (unit_ready),
  .cpu_irq    (cpu_irq),
  .cpu_ack    (cpu_ack),
  .msg_valid  (msg_valid),
  .msg_data   (msg_data),
  .msg_last   (msg_last),
  .msg_ready  (msg_ready)
);

// File: tb/irq_msg_arbiter_tb.sv
module irq_msg_arbiter_tb;
  localparam int N = 4;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   unit_req = '0;
  logic [N-1:0]   unit_ack;
  logic [N-1:0]   unit_valid = '0;
  logic [N*W-1:0] unit_data = '0;
  logic [N-1:0]   unit_ready;
  logic           cpu_irq;
  logic           cpu_ack = 1'b0;
  logic           msg_valid;
  logic [W-1:0]   msg_data;
  logic           msg_last;
  logic           msg_ready = 1'b0;

  irq_msg_arbiter #(.N_UNITS(N), .WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .unit_req(unit_req), .unit_ack(unit_ack),
    .unit_valid(unit_valid), .unit_data(unit_data), .unit_ready(unit_ready),
    .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_last(msg_last), .msg_ready(msg_ready)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // bench unit model state
  logic [N-1:0] req_b = '0;
  int           stage [N];
  int           seq   [N];
  logic [N-1:0] raise = '0;
  logic         noise = 1'b0;
  logic         nx_ack = 1'b0;
  logic         nx_ready = 1'b0;

  // negedge samples
  logic         s_irq, s_mv;
  logic [N-1:0] s_ack, s_urdy;
  logic [W-1:0] got_data [$];
  logic         got_last [$];

  function automatic logic [W-1:0] evt_word(int u, int s);
    return {8'hE1, 8'(u), 16'(s)};
  endfunction

  function automatic logic [W-1:0] par_word(int u, int s);
    return {8'hA7, 8'(u), 16'(s) ^ 16'h55AA};
  endfunction

  function automatic int lowest(logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [N-1:0]   v;
    logic [N*W-1:0] d;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (stage[i] != 0 && s_urdy[i]) begin
        if (stage[i] == 1) stage[i] = 2;
        else begin stage[i] = 0; seq[i]++; end
      end
      if (s_ack[i]) begin
        req_b[i] = 1'b0;
        stage[i] = 1;
      end
    end
    req_b = req_b | raise;
    raise = '0;
    for (int i = 0; i < N; i++) begin
      if (stage[i] == 1) begin
        v[i] = 1'b1; d[i*W +: W] = evt_word(i, seq[i]);
      end else if (stage[i] == 2) begin
        v[i] = 1'b1; d[i*W +: W] = par_word(i, seq[i]);
      end else begin
        v[i] = noise & $urandom_range(0, 1);
        d[i*W +: W] = $urandom;
      end
    end
    unit_req   <= req_b;
    unit_valid <= v;
    unit_data  <= d;
    cpu_ack    <= nx_ack;
    msg_ready  <= nx_ready;
    @(negedge clk);
    s_irq  = cpu_irq;
    s_ack  = unit_ack;
    s_urdy = unit_ready;
    s_mv   = msg_valid;
    if (msg_valid && msg_ready) begin
      got_data.push_back(msg_data);
      got_last.push_back(msg_last);
    end
  endtask

  // raise requests only on units that are neither pending nor sending
  task automatic raise_free(input logic [N-1:0] m);
    for (int i = 0; i < N; i++)
      if (m[i] && !req_b[i] && stage[i] == 0) raise[i] = 1'b1;
  endtask

  task automatic serve(input bit disturb);
    int           w;
    int           ex;
    int           exs;
    logic [N-1:0] pre;
    w = 0;
    nx_ready = 1'b0;
    while (!s_irq && w < 20) begin tick(); w++; end
    chk(s_irq, "R1 line up for pending request", s_irq, 1);
    nx_ack = 1'b1;
    tick();
    nx_ack = 1'b0;
    ex  = lowest(unit_req);
    exs = (ex >= 0) ? seq[ex] : 0;
    tick();
    chk(ex >= 0 && s_ack == (N'(1) << ex), "R2 acknowledge to lowest requester", s_ack, N'(1) << ex);
    chk(!s_irq, "R7 line low on acknowledge", s_irq, 0);
    if (ex < 0) return;
    got_data.delete();
    got_last.delete();
    w = 0;
    while (got_data.size() < 2 && w < 60) begin
      if (disturb && w == 1) begin
        nx_ack = 1'b1;
        raise_free({N{1'b1}});
        noise = 1'b1;
      end else nx_ack = 1'b0;
      nx_ready = ($urandom_range(0, 3) != 0);
      tick();
      w++;
      chk(!s_irq, "R7 line low during message", s_irq, 0);
      chk(s_ack == '0, "R3 no acknowledge during message", s_ack, 0);
      chk((s_urdy & ~(N'(1) << ex)) == '0, "R4 ready only to owner", s_urdy, N'(1) << ex);
    end
    nx_ack = 1'b0;
    pre = unit_req;
    nx_ready = 1'b0;
    tick();
    noise = 1'b0;
    chk(got_data.size() == 2, "R5 two words forwarded", got_data.size(), 2);
    if (got_data.size() == 2) begin
      chk(got_data[0] == evt_word(ex, exs) && got_last[0] == 1'b0,
          "R5 event word first", got_data[0], evt_word(ex, exs));
      chk(got_data[1] == par_word(ex, exs) && got_last[1] == 1'b1,
          "R5 parameter word last", got_data[1], par_word(ex, exs));
    end
    chk(s_irq == (|pre), "R8 line recomputed after last word", s_irq, |pre);
    tick();
    chk(!s_mv, "R5 no extra word", s_mv, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    for (int i = 0; i < N; i++) begin stage[i] = 0; seq[i] = 0; end
    s_ack = '0; s_urdy = '0; s_irq = 1'b0; s_mv = 1'b0;
    rst = 1'b1;
    repeat (4) tick();
    rst <= 1'b0;
    tick();
    // R9 reset state
    chk(!s_irq && s_ack == '0 && s_urdy == '0 && !s_mv, "R9 reset state",
        {s_irq, s_ack, s_urdy, s_mv}, 0);

    // R3 stray acknowledge with the line low and nothing pending
    nx_ack = 1'b1;
    tick();
    nx_ack = 1'b0;
    tick();
    chk(s_ack == '0 && !s_irq, "R3 acknowledge ignored when line low", s_ack, 0);
    tick();
    chk(!s_mv, "R3 no message after ignored acknowledge", s_mv, 0);

    // R1 single request raises the line one edge after it is seen
    raise_free(4'b0100);
    tick();
    tick();
    chk(s_irq, "R1 line follows request", s_irq, 1);
    serve(1'b0);

    // all at once: served strictly by index
    raise_free({N{1'b1}});
    tick();
    for (int k = 0; k < N; k++) serve(1'b0);
    tick();
    chk(!s_irq, "R1 line low with no requests", s_irq, 0);

    // disturbed message: stray ack, late requests, noise on idle units
    raise_free(4'b1000);
    tick();
    serve(1'b1);
    while (s_irq || unit_req != '0) serve(1'b0);

    // random request masks
    for (int it = 0; it < 40; it++) begin
      raise_free(N'($urandom_range(1, (1 << N) - 1)));
      tick();
      serve(it % 5 == 0);
    end
    while (unit_req != '0) serve(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule